// File: doc/BRIEF.md
# Programmable Interval Timer with Shared-Counter Prescaler

This peripheral gives a small 8-bit system a programmable periodic interrupt. A 16-bit free-running counter advances on every clock. Its upper byte can be read as a coarse divider. One of its bits, chosen by a control field, is gated by an enable bit. A falling-edge detector watches the gated bit and advances an 8-bit timer counter. When the timer counter passes 0xFF, it is reloaded from a programmable modulo register and a single-cycle interrupt request is raised.

Software reaches four byte registers through a simple bus. Writes use a one-cycle strobe with a 16-bit address and 8-bit data. Reads are combinational from the address. The rate is derived from the shared counter and not from a private prescaler. Because of this, clearing the divider or turning off the enable while the watched bit is high produces one extra count. Software that reprograms the timer has to allow for it.

Top module: `prog_timer`

## Requirements
- R1: The 16-bit free-running counter increments by one every clock. Reading offset 0 (the divider) returns counter bits 15:8.
- R2: A write of any data to offset 0 clears the whole 16-bit free-running counter to zero at that clock edge.
- R3: Control bits 1:0 choose the watched counter bit: 00 selects bit 9, 01 selects bit 3, 10 selects bit 5 and 11 selects bit 7. With the free-running counter cleared at edge 0 and the timer enabled from edge 1, the timer counter has advanced floor((n-1)/2^(b+1)) times after edge n.
- R4: Control bit 2 is the enable. While it is 0 the timer counter does not advance.
- R5: The timer counter advances once per 1-to-0 change of (enable AND watched bit), compared against the previous cycle. Clearing the divider, or clearing the enable, while the watched bit is 1 therefore adds one count on the following edge.
- R6: An advance from 0xFF loads the timer counter with the modulo value. The same edge raises irq_pulse for exactly one clock.
- R7: Reading offset 3 (control) returns 1 in bits 7:3 and the written value in bits 2:0.
- R8: A bus write to offset 1 (the timer counter) in the same cycle as an advance stores the written value. The advance is dropped.
- R9: Offsets 1 and 2 read back the timer counter and the modulo register. A modulo write is used at the next reload.
- R10: After reset the timer counter and modulo read 0x00, control reads 0xF8, irq_pulse is 0, and a read of an address outside the four registers returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | One-cycle write strobe |
| bus_addr | input | 16 | Byte address; offsets 0..3 from BASE_ADDR (default 0xFF04) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| irq_pulse | output | 1 | One-clock timer overflow request |

## Verification
A wrong free-running count shows up in the divider read within 256 clocks. It also shifts the edge at which the timer counter advances, so a count read one edge before and one edge after each expected advance catches an off-by-one at once. A stale edge flop shows as a missing or doubled count on the edge right after a divider clear or an enable clear. A wrong reload source or a stretched interrupt appears on the overflow edge and the edge after it.

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter logic [15:0] BASE_ADDR = 16'hFF04,
  parameter int          SYS_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [15:0] bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        irq_pulse
);
  localparam logic [15:0] A_DIV  = BASE_ADDR;
  localparam logic [15:0] A_CNT  = BASE_ADDR + 16'd1;
  localparam logic [15:0] A_MOD  = BASE_ADDR + 16'd2;
  localparam logic [15:0] A_CTRL = BASE_ADDR + 16'd3;

  logic [SYS_W-1:0] sys_q;
  logic [7:0]       cnt_q, mod_q;
  logic [2:0]       ctrl_q;
  logic             prev_q, irq_q;
  logic             tap, sig, fall;

  wire wr_div  = bus_we && bus_addr == A_DIV;
  wire wr_cnt  = bus_we && bus_addr == A_CNT;
  wire wr_mod  = bus_we && bus_addr == A_MOD;
  wire wr_ctrl = bus_we && bus_addr == A_CTRL;

  always_comb begin
    case (ctrl_q[1:0])
      2'b00:   tap = sys_q[9];
      2'b01:   tap = sys_q[3];
      2'b10:   tap = sys_q[5];
      default: tap = sys_q[7];
    endcase
  end

  assign sig  = tap & ctrl_q[2];
  assign fall = prev_q & ~sig;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sys_q  <= '0;
      cnt_q  <= 8'h00;
      mod_q  <= 8'h00;
      ctrl_q <= 3'b000;
      prev_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      sys_q  <= wr_div ? '0 : sys_q + 1'b1;
      prev_q <= sig;
      irq_q  <= 1'b0;
      if (wr_mod)  mod_q  <= bus_wdata;
      if (wr_ctrl) ctrl_q <= bus_wdata[2:0];
      if (wr_cnt) cnt_q <= bus_wdata;
      else if (fall) begin
        if (cnt_q == 8'hFF) begin
          cnt_q <= mod_q;
          irq_q <= 1'b1;
        end else cnt_q <= cnt_q + 8'd1;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_DIV:   bus_rdata = sys_q[SYS_W-1 -: 8];
      A_CNT:   bus_rdata = cnt_q;
      A_MOD:   bus_rdata = mod_q;
      A_CTRL:  bus_rdata = {5'b11111, ctrl_q};
      default: bus_rdata = 8'hFF;
    endcase
  end

  assign irq_pulse = irq_q;

  p_div_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_div |=> sys_q == '0);
  p_free_run_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_div |=> sys_q == $past(sys_q) + 1'b1);
  p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> cnt_q == $past(mod_q));
  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_cnt) && cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 8'd1 || irq_pulse));
  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(bus_wdata) && !irq_pulse));
  p_disabled_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[2] && !prev_q && !wr_cnt) |=> $stable(cnt_q));
endmodule

// File: tb/sim_prog_timer.sv
`timescale 1ns/1ps
module sim_prog_timer;
  localparam logic [15:0] A_DIV = 16'hFF04, A_CNT = 16'hFF05, A_MOD = 16'hFF06, A_CTRL = 16'hFF07;

  logic clk = 0, rst_n = 0, bus_we = 0, irq_pulse;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  int checks = 0, fails = 0, n = 0;

  prog_timer u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
                 .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pulse(irq_pulse));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk); @(negedge clk);
    bus_we = 0;
  endtask

  task automatic setup(input logic [1:0] sel, input logic [7:0] c0, input logic [7:0] m);
    wr(A_CTRL, {6'b0, sel});
    wr(A_MOD, m);
    wr(A_CNT, c0);
    wr(A_DIV, 8'hA5);
    wr(A_CTRL, {5'b0, 1'b1, sel});
    n = 1;
  endtask

  task automatic adv(input int t);
    repeat (t - n) @(posedge clk);
    #0.1;
    @(negedge clk);
    n = t;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1;
    rd(A_CNT, d);  chk("R10 counter reset", d, 8'h00);
    rd(A_MOD, d);  chk("R10 modulo reset", d, 8'h00);
    rd(A_CTRL, d); chk("R10 control reset", d, 8'hF8);
    rd(16'h1234, d); chk("R10 unmapped read", d, 8'hFF);
    chk("R10 irq reset", irq_pulse, 1'b0);

    wr(A_CTRL, 8'h05); rd(A_CTRL, d); chk("R7 control 05", d, 8'hFD);
    wr(A_CTRL, 8'h02); rd(A_CTRL, d); chk("R7 control 02", d, 8'hFA);
    wr(A_MOD, 8'h5A);  rd(A_MOD, d);  chk("R9 modulo readback", d, 8'h5A);
    wr(A_CNT, 8'hC3);  rd(A_CNT, d);  chk("R9 counter readback", d, 8'hC3);

    // R3 sweep over every select value with R1 divider checks
    for (int s = 0; s < 4; s++) begin
      int b, p;
      b = (s == 0) ? 9 : (s == 1) ? 3 : (s == 2) ? 5 : 7;
      p = 1 << (b + 1);
      setup(s[1:0], 8'h00, 8'h00);
      for (int k = 1; k <= 3; k++) begin
        adv(k * p);
        rd(A_CNT, d); chk($sformatf("R3 sel%0d before edge k%0d", s, k), d, 8'(k - 1));
        rd(A_DIV, d); chk($sformatf("R1 divider n%0d", n), d, 8'(n >> 8));
        adv(k * p + 1);
        rd(A_CNT, d); chk($sformatf("R3 sel%0d after edge k%0d", s, k), d, 8'(k));
      end
    end

    // R6 overflow reload and one-cycle interrupt, R9 modulo used
    setup(2'b01, 8'hFE, 8'hF0);
    adv(32); rd(A_CNT, d); chk("R6 pre-overflow", d, 8'hFF); chk("R6 irq low", irq_pulse, 1'b0);
    adv(33); rd(A_CNT, d); chk("R6 reload", d, 8'hF0); chk("R6 irq high", irq_pulse, 1'b1);
    adv(34); chk("R6 irq single", irq_pulse, 1'b0);
    adv(49); rd(A_CNT, d); chk("R6 continue after reload", d, 8'hF1);

    // R5 extra count on divider clear while bit 3 high, R2 clear
    setup(2'b01, 8'h00, 8'h00);
    adv(11);
    wr(A_DIV, 8'h00);
    rd(A_DIV, d); chk("R2 divider cleared", d, 8'h00);
    @(posedge clk); #0.1; @(negedge clk);
    rd(A_CNT, d); chk("R5 extra count on divider clear", d, 8'h01);
    repeat (15) @(posedge clk); #0.1; @(negedge clk);
    rd(A_CNT, d); chk("R5 no count before next edge", d, 8'h01);
    @(posedge clk); #0.1; @(negedge clk);
    rd(A_CNT, d); chk("R5 next natural count", d, 8'h02);

    // R5 extra count on enable clear, then R4 no counting while disabled
    setup(2'b01, 8'h00, 8'h00);
    adv(11);
    wr(A_CTRL, 8'h01);
    @(posedge clk); #0.1; @(negedge clk);
    rd(A_CNT, d); chk("R5 extra count on enable clear", d, 8'h01);
    repeat (200) @(posedge clk); #0.1; @(negedge clk);
    rd(A_CNT, d); chk("R4 disabled holds", d, 8'h01);

    // R8 bus write collides with an advance
    setup(2'b01, 8'h00, 8'h00);
    adv(16);
    wr(A_CNT, 8'h40);
    rd(A_CNT, d); chk("R8 write wins", d, 8'h40);
    n = 17;
    adv(33); rd(A_CNT, d); chk("R8 counting resumes", d, 8'h41);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule